// File: doc/BRIEF.md
# Nibble accumulator and pointer datapath

This block is the data half of a small 4-bit controller. It holds a 4-bit accumulator, a 6-bit data pointer and two flags: zero and carry. The pointer has a 2-bit upper part and a 4-bit lower part. A 64-entry nibble RAM sits inside the block and is addressed by the full pointer.

A sequencer outside the block fetches and decodes instructions. Each cycle it may present one decoded operation code, together with a 4-bit immediate and a valid strobe. The block carries out the operation at the next rising clock edge. It reports the accumulator and both flags back to the sequencer, which uses them to decide conditional branches.

The operations are:
- load an immediate into the accumulator;
- compare the accumulator with an immediate;
- store the accumulator to RAM, and load it from RAM;
- set the pointer halves;
- step the lower pointer half up or down;
- copy between the accumulator and the lower pointer half.

Top module: `nx_core`

## Requirements
- R1: After reset is released (`rst_n` low, active-low, synchronous to `clk`), the accumulator, both flags and both pointer halves are 0.
- R2: Operation code 1 (load immediate) writes `op_imm` into the accumulator. It sets the zero flag exactly when `op_imm` is 0 and keeps the carry flag.
- R3: Operation code 2 (compare) leaves the accumulator unchanged. It sets the carry flag when `op_imm` <= accumulator (unsigned), and sets the zero flag when `op_imm` == accumulator.
- R4: Operation code 3 (store) writes the accumulator into RAM at address {upper,lower} with the upper half as the high bits. Operation code 4 (load) reads that address into the accumulator and updates the zero flag from the value read. Neither operation touches the carry flag.
- R5: Operation code 5 clears the upper pointer half and writes `op_imm` to the lower half. Both flags are kept.
- R6: Operation code 6 writes `op_imm[1:0]` to the upper pointer half. The lower half and both flags are kept.
- R7: Operation code 7 adds 1 to the lower pointer half, and code 8 subtracts 1. Both wrap modulo 16 and set the zero flag from the new lower half. Neither changes the upper half or the carry flag.
- R8: Operation code 9 copies the accumulator into the lower pointer half and leaves both flags unchanged.
- R9: Operation code 10 copies the lower pointer half into the accumulator and sets the zero flag from the copied value.
- R10: When `op_valid` is low, or when the code is 0 or 11 to 15, no register or RAM entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 4 | Decoded operation code (see requirements) |
| op_imm | input | 4 | Immediate nibble of the operation |
| ac_o | output | 4 | Accumulator value |
| zf_o | output | 1 | Zero flag |
| cf_o | output | 1 | Carry flag |

## Verification
The pointer's upper half cannot be seen at any port, so it is the hardest state to check. It shows only through which RAM cell a load returns. The stimulus first fills all 64 cells with values that differ between neighbours. It then reads every cell back by setting the two halves separately. Stepping the lower half through its wrap points is followed by a RAM load, so a corrupted upper half returns a value from the wrong row. A compare sweep covers all 256 pairs of accumulator and immediate.

// File: rtl/nx_pkg.sv
package nx_pkg;

    localparam int NX_DW  = 4;
    localparam int NX_HW  = 2;
    localparam int NX_AW  = NX_HW + NX_DW;

    typedef enum logic [3:0] {
        OP_NOP = 4'd0,
        OP_LDI = 4'd1,
        OP_CMP = 4'd2,
        OP_STM = 4'd3,
        OP_LDM = 4'd4,
        OP_LDP = 4'd5,
        OP_LPH = 4'd6,
        OP_INC = 4'd7,
        OP_DEC = 4'd8,
        OP_TAD = 4'd9,
        OP_TDA = 4'd10
    } nx_op_e;

    typedef struct packed {
        logic [NX_DW-1:0] ac;
        logic             zf;
        logic             cf;
        logic [NX_HW-1:0] dph;
        logic [NX_DW-1:0] dpl;
    } nx_state_t;

endpackage

// File: rtl/nx_alu.sv
module nx_alu #(
    parameter int DW = 4
) (
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] imm,
    input  logic [DW-1:0] ptr,
    output logic          cmp_carry,
    output logic          cmp_zero,
    output logic [DW-1:0] ptr_inc,
    output logic [DW-1:0] ptr_dec
);
    logic [DW:0] diff;

    always_comb begin
        diff      = {1'b0, acc} + {1'b0, ~imm} + {{DW{1'b0}}, 1'b1};
        cmp_carry = diff[DW];
        cmp_zero  = (diff[DW-1:0] == '0);
        ptr_inc   = ptr + {{(DW-1){1'b0}}, 1'b1};
        ptr_dec   = ptr - {{(DW-1){1'b0}}, 1'b1};
    end
endmodule

// File: rtl/nx_zero.sv
module nx_zero #(
    parameter int W = 4
) (
    input  logic [W-1:0] val,
    output logic         is_zero
);
    assign is_zero = ~|val;
endmodule

// File: rtl/nx_ram.sv
module nx_ram #(
    parameter int DW = 4,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/nx_core.sv
module nx_core
    import nx_pkg::*;
#(
    parameter int DW = NX_DW,
    parameter int HW = NX_HW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op_sel,
    input  logic [DW-1:0] op_imm,
    output logic [DW-1:0] ac_o,
    output logic          zf_o,
    output logic          cf_o
);
    localparam int AW = HW + DW;

    nx_state_t      st_d, st_q;
    nx_op_e         op;
    logic [DW-1:0]  res;
    logic           res_upd;
    logic           res_zero;
    logic           ram_we;
    logic [DW-1:0]  ram_rd;
    logic           cmp_carry, cmp_zero;
    logic [DW-1:0]  ptr_inc, ptr_dec;

    assign op = nx_op_e'(op_sel);

    nx_alu #(.DW(DW)) u_alu (
        .acc       (st_q.ac),
        .imm       (op_imm),
        .ptr       (st_q.dpl),
        .cmp_carry (cmp_carry),
        .cmp_zero  (cmp_zero),
        .ptr_inc   (ptr_inc),
        .ptr_dec   (ptr_dec)
    );

    nx_ram #(.DW(DW), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  ({st_q.dph, st_q.dpl}),
        .wdata (st_q.ac),
        .rdata (ram_rd)
    );

    // result nibble whose zero-ness feeds the zero flag
    always_comb begin
        res     = st_q.ac;
        res_upd = 1'b0;
        if (op_valid) begin
            case (op)
                OP_LDI: begin res = op_imm;  res_upd = 1'b1; end
                OP_LDM: begin res = ram_rd;  res_upd = 1'b1; end
                OP_INC: begin res = ptr_inc; res_upd = 1'b1; end
                OP_DEC: begin res = ptr_dec; res_upd = 1'b1; end
                OP_TDA: begin res = st_q.dpl; res_upd = 1'b1; end
                default: begin res = st_q.ac; res_upd = 1'b0; end
            endcase
        end
    end

    nx_zero #(.W(DW)) u_zero (
        .val     (res),
        .is_zero (res_zero)
    );

    always_comb begin
        st_d   = st_q;
        ram_we = 1'b0;
        if (op_valid) begin
            case (op)
                OP_LDI: st_d.ac = op_imm;
                OP_CMP: begin
                    st_d.cf = cmp_carry;
                    st_d.zf = cmp_zero;
                end
                OP_STM: ram_we = 1'b1;
                OP_LDM: st_d.ac = ram_rd;
                OP_LDP: begin
                    st_d.dph = '0;
                    st_d.dpl = op_imm;
                end
                OP_LPH: st_d.dph = op_imm[HW-1:0];
                OP_INC: st_d.dpl = ptr_inc;
                OP_DEC: st_d.dpl = ptr_dec;
                OP_TAD: st_d.dpl = st_q.ac;
                OP_TDA: st_d.ac  = st_q.dpl;
                default: st_d = st_q;
            endcase
        end
        if (res_upd) begin
            st_d.zf = res_zero;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ac_o = st_q.ac;
    assign zf_o = st_q.zf;
    assign cf_o = st_q.cf;
endmodule

// File: rtl/nx_core_chk.sv
module nx_core_chk
    import nx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [3:0] op_sel,
    input logic [3:0] op_imm,
    input logic [3:0] ac,
    input logic       zf,
    input logic       cf,
    input logic [1:0] dph,
    input logic [3:0] dpl
);
    p_ldi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_LDI) |=>
            (ac == $past(op_imm)) && (zf == ($past(op_imm) == 4'd0)) && $stable(cf));

    p_cmp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_CMP) |=>
            $stable(ac) && (cf == ($past(op_imm) <= $past(ac)))
            && (zf == ($past(op_imm) == $past(ac))));

    p_ldp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_LDP) |=>
            (dph == 2'd0) && (dpl == $past(op_imm)) && $stable(zf) && $stable(cf));

    p_lph_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_LPH) |=>
            (dph == $past(op_imm[1:0])) && $stable(dpl) && $stable(zf) && $stable(cf));

    p_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_INC) |=>
            (dpl == 4'($past(dpl) + 4'd1)) && $stable(dph) && $stable(cf)
            && (zf == (dpl == 4'd0)));

    p_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_DEC) |=>
            (dpl == 4'($past(dpl) - 4'd1)) && $stable(dph) && $stable(cf)
            && (zf == (dpl == 4'd0)));

    p_tad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_TAD) |=>
            (dpl == $past(ac)) && $stable(zf) && $stable(cf) && $stable(ac));

    p_tda_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_TDA) |=>
            (ac == $past(dpl)) && (zf == (ac == 4'd0)) && $stable(cf));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_sel == OP_NOP || op_sel > OP_TDA) |=>
            $stable(ac) && $stable(zf) && $stable(cf) && $stable(dph) && $stable(dpl));
endmodule

bind nx_core nx_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_sel   (op_sel),
    .op_imm   (op_imm),
    .ac       (ac_o),
    .zf       (zf_o),
    .cf       (cf_o),
    .dph      (st_q.dph),
    .dpl      (st_q.dpl)
);

// File: tb/test_nx_core.sv
module test_nx_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_sel = 4'd0;
    logic [3:0] op_imm = 4'd0;
    logic [3:0] ac_o;
    logic       zf_o, cf_o;

    int total = 0;
    int bad = 0;

    // bench model, built from the requirements
    logic [3:0] m_ac = 4'd0, m_dpl = 4'd0;
    logic [1:0] m_dph = 2'd0;
    logic       m_zf = 1'b0, m_cf = 1'b0;
    logic [3:0] m_mem [64];

    nx_core i_nx_core (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .op_imm(op_imm), .ac_o(ac_o), .zf_o(zf_o), .cf_o(cf_o)
    );

    always #5 clk = ~clk;

    task automatic check(string req);
        total++;
        if ({ac_o, zf_o, cf_o} !== {m_ac, m_zf, m_cf}) begin
            bad++;
            $display("FAIL %s ac/zf/cf got=%h/%b/%b exp=%h/%b/%b",
                     req, ac_o, zf_o, cf_o, m_ac, m_zf, m_cf);
        end
    endtask

    task automatic run(input logic [3:0] op, input logic [3:0] imm, input logic vld);
        @(negedge clk);
        op_valid = vld;
        op_sel   = op;
        op_imm   = imm;
        @(posedge clk);
        #2;
        op_valid = 1'b0;
        if (vld) begin
            case (op)
                4'd1: begin m_ac = imm; m_zf = (imm == 4'd0); end
                4'd2: begin m_cf = (imm <= m_ac); m_zf = (imm == m_ac); end
                4'd3: m_mem[{m_dph, m_dpl}] = m_ac;
                4'd4: begin m_ac = m_mem[{m_dph, m_dpl}]; m_zf = (m_ac == 4'd0); end
                4'd5: begin m_dph = 2'd0; m_dpl = imm; end
                4'd6: m_dph = imm[1:0];
                4'd7: begin m_dpl = m_dpl + 4'd1; m_zf = (m_dpl == 4'd0); end
                4'd8: begin m_dpl = m_dpl - 4'd1; m_zf = (m_dpl == 4'd0); end
                4'd9: m_dpl = m_ac;
                4'd10: begin m_ac = m_dpl; m_zf = (m_ac == 4'd0); end
                default: ;
            endcase
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #1_500_000;
        total++;
        bad++;
        $display("FAIL watchdog expired got=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset state");
        run(4'd10, 4'd0, 1'b1);
        check("R1 lower pointer zero after reset");

        // R2: every immediate
        for (int v = 0; v < 16; v++) begin
            run(4'd1, 4'(v), 1'b1);
            check("R2 load immediate");
        end

        // R3: all accumulator / immediate pairs
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                run(4'd1, 4'(a), 1'b1);
                run(4'd2, 4'(b), 1'b1);
                check("R3 compare");
            end
        end

        // R4/R5/R6: fill all 64 cells through split pointer writes
        for (int h = 0; h < 4; h++) begin
            for (int l = 0; l < 16; l++) begin
                run(4'd5, 4'(l), 1'b1);
                check("R5 pointer load keeps flags");
                run(4'd6, 4'(h), 1'b1);
                check("R6 upper pointer load keeps flags");
                run(4'd1, 4'(h * 5 + l * 3 + 1), 1'b1);
                run(4'd3, 4'd0, 1'b1);
                check("R4 store keeps state");
            end
        end
        for (int h = 0; h < 4; h++) begin
            for (int l = 0; l < 16; l++) begin
                run(4'd5, 4'(l), 1'b1);
                run(4'd6, 4'(h), 1'b1);
                run(4'd4, 4'd0, 1'b1);
                check("R4 load from addressed cell");
            end
        end
        // R5: pointer load clears a nonzero upper half
        run(4'd6, 4'd3, 1'b1);
        run(4'd5, 4'd7, 1'b1);
        run(4'd4, 4'd0, 1'b1);
        check("R5 upper half cleared");
        // R6: only two bits of the immediate reach the upper half
        run(4'd5, 4'd9, 1'b1);
        run(4'd6, 4'hE, 1'b1);
        run(4'd4, 4'd0, 1'b1);
        check("R6 upper half takes low two bits");

        // R7: step up and down through the wrap, upper half 2
        run(4'd2, 4'd0, 1'b1);
        run(4'd5, 4'd12, 1'b1);
        run(4'd6, 4'd2, 1'b1);
        for (int i = 0; i < 20; i++) begin
            run(4'd7, 4'd0, 1'b1);
            check("R7 increment flags");
        end
        run(4'd4, 4'd0, 1'b1);
        check("R7 upper half kept after increments");
        run(4'd10, 4'd0, 1'b1);
        check("R7 lower half after increments");
        for (int i = 0; i < 20; i++) begin
            run(4'd8, 4'd0, 1'b1);
            check("R7 decrement flags");
        end
        run(4'd4, 4'd0, 1'b1);
        check("R7 upper half kept after decrements");
        run(4'd10, 4'd0, 1'b1);
        check("R7 lower half after decrements");

        // R8/R9: transfers in both directions
        for (int v = 0; v < 16; v++) begin
            run(4'd1, 4'(v), 1'b1);
            run(4'd2, 4'(v ^ 5), 1'b1);
            run(4'd9, 4'd0, 1'b1);
            check("R8 copy to pointer keeps flags");
            run(4'd1, 4'(v ^ 15), 1'b1);
            run(4'd10, 4'd0, 1'b1);
            check("R9 copy from pointer");
        end

        // R10: strobe low and undefined codes change nothing
        run(4'd1, 4'd6, 1'b1);
        run(4'd2, 4'd3, 1'b1);
        run(4'd5, 4'd4, 1'b1);
        run(4'd3, 4'd0, 1'b1);
        for (int c = 0; c < 16; c++) begin
            run(4'(c), 4'd11, 1'b0);
            check("R10 strobe low");
        end
        run(4'd0, 4'd1, 1'b1);
        check("R10 code 0");
        for (int c = 11; c < 16; c++) begin
            run(4'(c), 4'd1, 1'b1);
            check("R10 undefined code");
        end
        run(4'd4, 4'd0, 1'b1);
        check("R10 ram and pointer untouched");
        run(4'd10, 4'd0, 1'b1);
        check("R10 lower pointer untouched");

        finish_run();
    end
endmodule